// File: doc/BRIEF.md
# Prescaled PWM Core

A single pulse-width-modulation channel. Its period comes from a chosen time base run through two prescale stages and then a slot counter. Three clock-enable ticks arrive from outside: slow, medium and fast. A two-bit source code picks one of them, or none, in which case the channel halts. The chosen tick first passes through a small divider (2, 3, 5 or 6), then a power-of-two divider (2^m, m from 0 to 7). The result advances a slot counter that wraps every 64 or every 512 steps, depending on the resolution bit.

The pin is high while the slot counter is below the duty value. The duty comes either from a local register input or from an external sequencer port. A select bit chooses between them. New duty and resolution values are taken only when a period closes, so a change never produces a runt pulse. The pin toggles only while both the channel-enable and the pin-enable inputs are set. Otherwise the pin is low and every counter is held at zero, so enabling always starts a fresh period at slot 0.

Top module: `pwmp_core`

## Requirements
- R1: The output period is D * 2^m * N ticks of the selected source, where N = 64 when `wide_mode` = 0 and N = 512 when `wide_mode` = 1.
- R2: `prediv_sel` values 0, 1, 2 and 3 give D = 2, 3, 5 and 6.
- R3: `exp_sel` is a 3-bit exponent m, and every value from 0 to 7 is honoured, including m = 7.
- R4: `clk_sel` 0 selects no tick and freezes the channel. Codes 1, 2 and 3 select `tick_slow`, `tick_med` and `tick_fast`. A selected tick that stays low also freezes the channel.
- R5: With `wide_mode` = 1 all 9 duty bits are used. With `wide_mode` = 0 only duty bits [5:0] are used and bits [8:6] are ignored.
- R6: `pwm_out` is low whenever `pwm_en` or `out_en` is 0.
- R7: `bypass_seq` = 1 takes the duty from `duty_reg`. `bypass_seq` = 0 takes it from `duty_seq`.
- R8: Within a period, `pwm_out` is high for the first `duty` slots and low for the rest. Duty 0 is constantly low, and duty 63 in narrow mode leaves exactly one low slot.
- R9: A duty change reaches the output only at the period boundary. The value present in the last cycle of a period governs the whole next period.
- R10: While disabled, all counters are held at zero. When enabled, the output starts at slot 0 of a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_slow | input | 1 | Slow time-base enable pulse |
| tick_med | input | 1 | Medium time-base enable pulse |
| tick_fast | input | 1 | Fast time-base enable pulse |
| clk_sel | input | 2 | Source select: 0 none, 1 slow, 2 medium, 3 fast |
| prediv_sel | input | 2 | First-stage divide code: 0..3 gives 2, 3, 5, 6 |
| exp_sel | input | 3 | Second-stage exponent m, divide by 2^m |
| wide_mode | input | 1 | 1 = 9-bit slot counter, 0 = 6-bit |
| bypass_seq | input | 1 | 1 = duty from duty_reg, 0 = duty from duty_seq |
| duty_reg | input | 9 | Register duty value |
| duty_seq | input | 9 | Sequencer duty value |
| pwm_en | input | 1 | Channel enable |
| out_en | input | 1 | Pin enable |
| pwm_out | output | 1 | PWM pin |

## Verification
A duty update and the period boundary can land in the same cycle. This is the case where the sampling edge must pick up the new value. The bench writes a new duty in exactly the last cycle of one period, and writes another in the first cycle of a later period. It then counts the high cycles of each period separately. The first write must govern the very next period. The second must wait one full period before it takes effect.

// File: rtl/pwmp_pkg.sv
package pwmp_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_MED  = 2'd2,
    SRC_FAST = 2'd3
  } src_sel_e;

  // first-stage divide ratio for each code
  function automatic logic [2:0] prediv_of(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/pwmp_src_mux.sv
module pwmp_src_mux
  import pwmp_pkg::*;
(
  input  logic       tick_slow,
  input  logic       tick_med,
  input  logic       tick_fast,
  input  logic [1:0] sel,
  output logic       tick
);
  always_comb begin
    case (src_sel_e'(sel))
      SRC_SLOW: tick = tick_slow;
      SRC_MED:  tick = tick_med;
      SRC_FAST: tick = tick_fast;
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwmp_prescale.sv
module pwmp_prescale
  import pwmp_pkg::*;
#(
  parameter int EXP_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [1:0]          div_code,
  input  logic [EXP_BITS-1:0] exp_m,
  output logic                step
);
  localparam int EXP_CNT_W = (1 << EXP_BITS) - 1;

  logic [2:0]           div_cnt;
  logic [2:0]           div_last;
  logic                 div_wrap;
  logic [EXP_CNT_W-1:0] exp_cnt;
  logic [EXP_CNT_W-1:0] exp_last;

  assign div_last = prediv_of(div_code) - 3'd1;
  assign div_wrap = tick && (div_cnt >= div_last);
  // 2^m - 1; the shift by the top exponent overflows to zero and wraps to all ones
  assign exp_last = ({{(EXP_CNT_W-1){1'b0}}, 1'b1} << exp_m) - 1'b1;
  assign step     = div_wrap && (exp_cnt >= exp_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      exp_cnt <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      exp_cnt <= '0;
    end else if (div_wrap) begin
      div_cnt <= '0;
      exp_cnt <= step ? '0 : exp_cnt + 1'b1;
    end else if (tick) begin
      div_cnt <= div_cnt + 3'd1;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= 3'd5); // R2
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick); // R4
  AST_IDLE_PRESCALE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_cnt == 3'd0 && exp_cnt == '0)); // R10
endmodule

// File: rtl/pwmp_slot_cnt.sv
module pwmp_slot_cnt #(
  parameter int HI_BITS = 9,
  parameter int LO_BITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  input  logic               wide_in,
  input  logic [HI_BITS-1:0] duty_in,
  output logic               boundary,
  output logic               pin
);
  localparam logic [HI_BITS-1:0] LAST_WIDE   = '1;
  localparam logic [HI_BITS-1:0] LAST_NARROW = HI_BITS'((1 << LO_BITS) - 1);

  logic               wide_q;
  logic [HI_BITS-1:0] duty_q;
  logic [HI_BITS-1:0] cnt;
  logic [HI_BITS-1:0] last;
  logic [HI_BITS-1:0] duty_masked;

  assign last        = wide_q ? LAST_WIDE : LAST_NARROW;
  assign duty_masked = duty_in & (wide_in ? LAST_WIDE : LAST_NARROW);
  assign boundary    = step && (cnt == last);
  assign pin         = run && (cnt < duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wide_q <= 1'b0;
      duty_q <= '0;
    end else if (!run) begin
      cnt    <= '0;
      wide_q <= wide_in;
      duty_q <= duty_masked;
    end else if (step) begin
      if (boundary) begin
        cnt    <= '0;
        wide_q <= wide_in;
        duty_q <= duty_masked;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last); // R1
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> $stable(duty_q)); // R9
  AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R10
endmodule

// File: rtl/pwmp_core.sv
module pwmp_core
  import pwmp_pkg::*;
#(
  parameter int HI_BITS  = 9,
  parameter int LO_BITS  = 6,
  parameter int EXP_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_slow,
  input  logic                tick_med,
  input  logic                tick_fast,
  input  logic [1:0]          clk_sel,
  input  logic [1:0]          prediv_sel,
  input  logic [EXP_BITS-1:0] exp_sel,
  input  logic                wide_mode,
  input  logic                bypass_seq,
  input  logic [HI_BITS-1:0]  duty_reg,
  input  logic [HI_BITS-1:0]  duty_seq,
  input  logic                pwm_en,
  input  logic                out_en,
  output logic                pwm_out
);
  logic               run;
  logic               src_tick;
  logic               slot_step;
  logic               period_end;
  logic [HI_BITS-1:0] duty_pick;

  assign run       = pwm_en && out_en;
  assign duty_pick = bypass_seq ? duty_reg : duty_seq;

  pwmp_src_mux u_mux (
    .tick_slow (tick_slow),
    .tick_med  (tick_med),
    .tick_fast (tick_fast),
    .sel       (clk_sel),
    .tick      (src_tick)
  );

  pwmp_prescale #(.EXP_BITS(EXP_BITS)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (src_tick),
    .div_code (prediv_sel),
    .exp_m    (exp_sel),
    .step     (slot_step)
  );

  pwmp_slot_cnt #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .step     (slot_step),
    .wide_in  (wide_mode),
    .duty_in  (duty_pick),
    .boundary (period_end),
    .pin      (pwm_out)
  );

  AST_HALT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0) |-> !slot_step); // R4
  AST_PIN_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en || !out_en) |-> !pwm_out); // R6
  AST_BOUNDARY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (slot_step && run)); // R1
endmodule

// File: tb/pwmp_core_bench.sv
module pwmp_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_slow = 1'b0, tick_med = 1'b0, tick_fast = 1'b1;
  logic [1:0] clk_sel = 2'd3, prediv_sel = 2'd0;
  logic [2:0] exp_sel = 3'd0;
  logic       wide_mode = 1'b0, bypass_seq = 1'b1;
  logic [8:0] duty_reg = '0, duty_seq = '0;
  logic       pwm_en = 1'b0, out_en = 1'b0;
  logic       pwm_out;

  int n_run = 0, n_fail = 0;
  int hist [4];
  logic next_pin;

  always #4 clk = ~clk;

  pwmp_core u_pwmp_core (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_med(tick_med),
    .tick_fast(tick_fast), .clk_sel(clk_sel), .prediv_sel(prediv_sel),
    .exp_sel(exp_sel), .wide_mode(wide_mode), .bypass_seq(bypass_seq),
    .duty_reg(duty_reg), .duty_seq(duty_seq), .pwm_en(pwm_en),
    .out_en(out_en), .pwm_out(pwm_out)
  );

  function automatic int div_ratio(input int code);
    int r [4] = '{2, 3, 5, 6};
    return r[code];
  endfunction

  task automatic check(input string req, input int got, input int want);
    n_run++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  // disable, apply settings, let them load while idle
  task automatic setup(input int sel, input int dc, input int m, input int wide,
                       input int byp, input int dreg, input int dseq);
    @(negedge clk);
    pwm_en = 1'b0; out_en = 1'b0;
    clk_sel = 2'(sel); prediv_sel = 2'(dc); exp_sel = 3'(m);
    wide_mode = 1'(wide); bypass_seq = 1'(byp);
    duty_reg = 9'(dreg); duty_seq = 9'(dseq);
    @(negedge clk);
  endtask

  // enable at sample 0, count high cycles per period of length per,
  // optional duty_reg writes at cycle ka / kb; next_pin is sample n
  task automatic measure(input int n, input int per, input int en_p, input int en_o,
                         input int ka, input int va, input int kb, input int vb);
    for (int i = 0; i < 4; i++) hist[i] = 0;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k == 0) begin pwm_en = 1'(en_p); out_en = 1'(en_o); end
      if (k == ka) duty_reg = 9'(va);
      if (k == kb) duty_reg = 9'(vb);
      tick_slow = ((k % 4) == 3);
      #1;
      if (k == n) next_pin = pwm_out;
      else if (pwm_out) hist[(k / per) % 4]++;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int duties [4] = '{0, 1, 37, 63};
    repeat (3) @(negedge clk);
    #1 check("R6 reset pin low", int'(pwm_out), 0);
    rst_n = 1'b1;

    // sweep of divide code, exponent and duty (R1, R2, R8)
    for (int dc = 0; dc < 4; dc++)
      for (int m = 0; m < 3; m++)
        for (int di = 0; di < 4; di++) begin
          int t, p;
          t = div_ratio(dc) * (1 << m);
          p = t * 64;
          setup(3, dc, m, 0, 1, duties[di], 0);
          measure(p, p, 1, 1, -1, 0, -1, 0);
          check("R1 R2 R8 high cycles", hist[0], duties[di] * t);
          check("R1 R8 next period start", int'(next_pin), int'(duties[di] != 0));
        end

    // top exponent (R3)
    setup(3, 0, 7, 0, 1, 1, 0);
    measure(2 * 128 * 64, 2 * 128 * 64, 1, 1, -1, 0, -1, 0);
    check("R3 m=7 high cycles", hist[0], 256);
    check("R3 m=7 next period", int'(next_pin), 1);

    // wide mode and narrow masking (R5)
    setup(3, 0, 0, 1, 1, 300, 0);
    measure(1024, 1024, 1, 1, -1, 0, -1, 0);
    check("R5 wide duty 300", hist[0], 600);
    setup(3, 0, 0, 0, 1, 9'h1C5, 0);
    measure(128, 128, 1, 1, -1, 0, -1, 0);
    check("R5 narrow masks high bits", hist[0], 10);

    // duty source select (R7)
    setup(3, 0, 0, 0, 0, 50, 20);
    measure(128, 128, 1, 1, -1, 0, -1, 0);
    check("R7 sequencer duty", hist[0], 40);
    setup(3, 0, 0, 0, 1, 50, 20);
    measure(128, 128, 1, 1, -1, 0, -1, 0);
    check("R7 register duty", hist[0], 100);

    // enables (R6)
    setup(3, 0, 0, 0, 1, 63, 0);
    measure(128, 128, 0, 1, -1, 0, -1, 0);
    check("R6 pwm_en low", hist[0], 0);
    setup(3, 0, 0, 0, 1, 63, 0);
    measure(128, 128, 1, 0, -1, 0, -1, 0);
    check("R6 out_en low", hist[0], 0);

    // source select and halt (R4)
    setup(0, 0, 0, 0, 1, 10, 0);
    measure(300, 300, 1, 1, -1, 0, -1, 0);
    check("R4 no source frozen", hist[0], 300);
    setup(2, 0, 0, 0, 1, 10, 0);
    measure(300, 300, 1, 1, -1, 0, -1, 0);
    check("R4 idle medium frozen", hist[0], 300);
    setup(1, 0, 0, 0, 1, 16, 0);
    measure(512, 512, 1, 1, -1, 0, -1, 0);
    check("R4 slow tick period", hist[0], 128);
    check("R4 slow tick next period", int'(next_pin), 1);

    // boundary-coincident update and late update (R9)
    setup(3, 0, 0, 0, 1, 10, 0);
    measure(512, 128, 1, 1, 127, 40, 256, 25);
    check("R9 period 0 old duty", hist[0], 20);
    check("R9 write in last cycle applies", hist[1], 80);
    check("R9 write after boundary waits", hist[2], 80);
    check("R9 applies next boundary", hist[3], 50);

    // re-enable restarts at slot 0 (R10)
    setup(3, 1, 0, 0, 1, 5, 0);
    measure(70, 192, 1, 1, -1, 0, -1, 0);
    setup(3, 1, 0, 0, 1, 5, 0);
    measure(192, 192, 1, 1, -1, 0, -1, 0);
    check("R10 fresh period after re-enable", hist[0], 15);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule